// File: doc/BRIEF.md
# Interrupt Identifier Classifier and Validator

This block sits on the path where a 64-bit interrupt identifier word is written or forwarded. One cycle after a word is strobed in, it reports the interrupt type, the identifier cut down to the implemented width (zero-extended), whether that identifier names a deliverable interrupt, and a one-cycle error pulse. The pulse fires only when local error reporting is enabled and the word is malformed.

A word is malformed when it has a set bit at or above the implemented width, or when it falls in the LPI range while LPIs are disallowed. Special identifiers (1020 to 1023) and identifiers in the reserved holes are reported as not valid. They raise no error.

The implemented width is taken from a configuration input while reset is held. It is then clamped into the legal window for the build: 14 to 24 bits with LPI support, and 5 to 10 bits without it (13 bits when the extended windows are built). It is also limited to the CPU-side identifier width, which is 16 or 24 bits.

Top module: `intid_checker`

## Requirements
- R1: A word strobed with `in_valid` in one cycle produces `out_valid` high in the next cycle with results for that word; no strobe gives `out_valid` low.
- R2: The width is captured from `cfg_width` only while `rst_n` is low, clamped to [14, min(24, CPU_ID_BITS)] with LPI support; changes to `cfg_width` after reset have no effect on results.
- R3: `out_id` equals the input word with every bit at or above the captured width cleared, zero-extended to the output width.
- R4: Any set input bit at or above the captured width gives `out_id_ok` = 0, `out_err` = 1 when reporting is enabled, and a type taken from the masked value.
- R5: `out_kind` encodes the masked identifier as follows: 0 = SGI (0-15), 1 = PPI (16-31), 2 = SPI (32-1019), 3 = special (1020-1023), 4 = extended PPI (1056-1119), 5 = extended SPI (4096-5119), 6 = LPI (8192 and up).
- R6: An LPI-range identifier with `lpi_allowed` low gives `out_id_ok` = 0 and `out_err` = 1 when reporting is enabled.
- R7: A special identifier gives `out_id_ok` = 0 and no error pulse.
- R8: Identifiers in 1024-1055, 1120-4095 and 5120-8191 give `out_kind` = 7, `out_id_ok` = 0 and no error pulse.
- R9: `out_err` is high only in a cycle where `out_valid` is high and the word was strobed with `err_report_en` high.
- R10: An in-range SGI, PPI, SPI, extended PPI, extended SPI, or permitted LPI gives `out_id_ok` = 1 and `out_err` = 0.
- R11: After reset, `out_valid`, `out_err`, `out_id_ok` and `out_id` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; width is captured while low |
| cfg_width | input | 5 | Requested implemented identifier width in bits |
| in_valid | input | 1 | Strobe for `in_data` |
| in_data | input | 64 | Identifier word to check |
| lpi_allowed | input | 1 | LPI-range identifiers are permitted |
| err_report_en | input | 1 | Local error reporting enable |
| out_valid | output | 1 | Results valid this cycle |
| out_kind | output | 3 | Interrupt type code |
| out_id | output | 24 | Masked, zero-extended identifier |
| out_id_ok | output | 1 | Identifier names a deliverable interrupt |
| out_err | output | 1 | One-cycle error pulse |

## Verification
The bench builds the block with its default parameters: a 64-bit input word, a 24-bit CPU-side identifier, LPI support, and the extended windows present. This build reaches every type code, including both edges of each extended window and the top LPI value. Three reset phases capture a width of 24, an oversized request clamped down to 24, and an undersized request clamped up to 14. Together they exercise the upper-bit check on both sides of each clamp limit and show that a post-reset width change is ignored.

// File: rtl/intid_pkg.sv
package intid_pkg;

   typedef enum logic [2:0] {
      IK_SGI      = 3'd0,
      IK_PPI      = 3'd1,
      IK_SPI      = 3'd2,
      IK_SPECIAL  = 3'd3,
      IK_EXT_PPI  = 3'd4,
      IK_EXT_SPI  = 3'd5,
      IK_LPI      = 3'd6,
      IK_RESERVED = 3'd7
   } intid_kind_e;

   localparam int WIDTH_FIELD_W = 5;

   // Window edges of the identifier partition
   localparam logic [31:0] SGI_LAST      = 32'd15;
   localparam logic [31:0] PPI_LAST      = 32'd31;
   localparam logic [31:0] SPI_LAST      = 32'd1019;
   localparam logic [31:0] SPECIAL_LAST  = 32'd1023;
   localparam logic [31:0] EPPI_FIRST    = 32'd1056;
   localparam logic [31:0] EPPI_LAST     = 32'd1119;
   localparam logic [31:0] ESPI_FIRST    = 32'd4096;
   localparam logic [31:0] ESPI_LAST     = 32'd5119;
   localparam logic [31:0] LPI_FIRST     = 32'd8192;

   function automatic logic [WIDTH_FIELD_W-1:0] clamp_width(
      input logic [WIDTH_FIELD_W-1:0] req,
      input int                       lo,
      input int                       hi);
      if (int'(req) < lo)      return WIDTH_FIELD_W'(lo);
      else if (int'(req) > hi) return WIDTH_FIELD_W'(hi);
      else                     return req;
   endfunction

endpackage

// File: rtl/intid_width_reg.sv
module intid_width_reg
   import intid_pkg::*;
#(
   parameter int CPU_ID_BITS = 24,
   parameter bit LPI_SUPPORT = 1'b1,
   parameter bit EXT_IDS     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WIDTH_FIELD_W-1:0] cfg_width,
   output logic [WIDTH_FIELD_W-1:0] width_q
);

   localparam int LO     = LPI_SUPPORT ? 14 : 5;
   localparam int HI_RAW = LPI_SUPPORT ? 24 : (EXT_IDS ? 13 : 10);
   localparam int HI     = (HI_RAW > CPU_ID_BITS) ? CPU_ID_BITS : HI_RAW;

   if (LO > HI) begin : g_bad_window
      $error("intid_width_reg: empty legal width window");
   end

   // Width is sampled only while reset is held, then frozen
   always_ff @(posedge clk) begin
      if (!rst_n) width_q <= clamp_width(cfg_width, LO, HI);
   end

endmodule

// File: rtl/intid_range_mask.sv
module intid_range_mask
   import intid_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ID_W   = 24
) (
   input  logic [DATA_W-1:0]        data,
   input  logic [WIDTH_FIELD_W-1:0] width,
   output logic [ID_W-1:0]          id_masked,
   output logic                     above
);

   logic [DATA_W-1:0] keep;

   for (genvar b = 0; b < DATA_W; b++) begin : g_keep
      if (b >= ID_W) begin : g_hi
         assign keep[b] = 1'b0;
      end else begin : g_lo
         assign keep[b] = (32'(width) > 32'(b));
      end
   end

   assign id_masked = data[ID_W-1:0] & keep[ID_W-1:0];
   assign above     = |(data & ~keep);

endmodule

// File: rtl/intid_classify.sv
module intid_classify
   import intid_pkg::*;
#(
   parameter int ID_W    = 24,
   parameter bit EXT_IDS = 1'b1
) (
   input  logic [ID_W-1:0] id,
   output intid_kind_e     kind
);

   logic [31:0] id32;
   logic        in_eppi;
   logic        in_espi;

   assign id32 = 32'(id);

   if (EXT_IDS) begin : g_ext
      assign in_eppi = (id32 >= EPPI_FIRST) && (id32 <= EPPI_LAST);
      assign in_espi = (id32 >= ESPI_FIRST) && (id32 <= ESPI_LAST);
   end else begin : g_no_ext
      assign in_eppi = 1'b0;
      assign in_espi = 1'b0;
   end

   always_comb begin
      if (id32 <= SGI_LAST)          kind = IK_SGI;
      else if (id32 <= PPI_LAST)     kind = IK_PPI;
      else if (id32 <= SPI_LAST)     kind = IK_SPI;
      else if (id32 <= SPECIAL_LAST) kind = IK_SPECIAL;
      else if (in_eppi)              kind = IK_EXT_PPI;
      else if (in_espi)              kind = IK_EXT_SPI;
      else if (id32 >= LPI_FIRST)    kind = IK_LPI;
      else                           kind = IK_RESERVED;
   end

endmodule

// File: rtl/intid_checker.sv
module intid_checker
   import intid_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int CPU_ID_BITS = 24,
   parameter bit LPI_SUPPORT = 1'b1,
   parameter bit EXT_IDS     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [4:0]               cfg_width,
   input  logic                     in_valid,
   input  logic [DATA_W-1:0]        in_data,
   input  logic                     lpi_allowed,
   input  logic                     err_report_en,
   output logic                     out_valid,
   output logic [2:0]               out_kind,
   output logic [CPU_ID_BITS-1:0]   out_id,
   output logic                     out_id_ok,
   output logic                     out_err
);

   localparam int ID_W = CPU_ID_BITS;

   if (!(CPU_ID_BITS == 16 || CPU_ID_BITS == 24)) begin : g_bad_cpu
      $error("intid_checker: CPU_ID_BITS must be 16 or 24");
   end
   if (DATA_W < CPU_ID_BITS) begin : g_bad_data
      $error("intid_checker: DATA_W narrower than identifier");
   end

   logic [WIDTH_FIELD_W-1:0] width_q;
   logic [ID_W-1:0]          id_m;
   logic                     above;
   intid_kind_e              kind;
   logic                     lpi_blocked;
   logic                     not_deliverable;
   logic                     ok_d;
   logic                     err_d;

   intid_width_reg #(
      .CPU_ID_BITS (CPU_ID_BITS),
      .LPI_SUPPORT (LPI_SUPPORT),
      .EXT_IDS     (EXT_IDS)
   ) u_width (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_width (cfg_width),
      .width_q   (width_q)
   );

   intid_range_mask #(
      .DATA_W (DATA_W),
      .ID_W   (ID_W)
   ) u_mask (
      .data      (in_data),
      .width     (width_q),
      .id_masked (id_m),
      .above     (above)
   );

   intid_classify #(
      .ID_W    (ID_W),
      .EXT_IDS (EXT_IDS)
   ) u_class (
      .id   (id_m),
      .kind (kind)
   );

   assign lpi_blocked     = (kind == IK_LPI) && !lpi_allowed;
   assign not_deliverable = (kind == IK_SPECIAL) || (kind == IK_RESERVED);
   assign ok_d            = !above && !lpi_blocked && !not_deliverable;
   assign err_d           = err_report_en && (above || lpi_blocked);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= 3'd0;
         out_id    <= '0;
         out_id_ok <= 1'b0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid && err_d;
         if (in_valid) begin
            out_kind  <= kind;
            out_id    <= id_m;
            out_id_ok <= ok_d;
         end
      end
   end

endmodule

// File: rtl/intid_checker_sva.sv
module intid_checker_sva #(
   parameter int CPU_ID_BITS = 24,
   parameter bit LPI_SUPPORT = 1'b1,
   parameter bit EXT_IDS     = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   lpi_allowed,
   input logic                   err_report_en,
   input logic                   out_valid,
   input logic [2:0]             out_kind,
   input logic [CPU_ID_BITS-1:0] out_id,
   input logic                   out_id_ok,
   input logic                   out_err,
   input logic [4:0]             width_q
);

   localparam int LO     = LPI_SUPPORT ? 14 : 5;
   localparam int HI_RAW = LPI_SUPPORT ? 24 : (EXT_IDS ? 13 : 10);
   localparam int HI     = (HI_RAW > CPU_ID_BITS) ? CPU_ID_BITS : HI_RAW;

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(width_q) >= LO) && (int'(width_q) <= HI));
   a_r2_width_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(width_q));
   a_r3_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_id >> width_q) == '0));
   a_r7_ok_excludes: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_id_ok) |-> (out_kind != 3'd3 && out_kind != 3'd7));
   a_r6_lpi_permission: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_id_ok && out_kind == 3'd6) |-> $past(lpi_allowed));
   a_r9_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);
   a_r9_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !err_report_en) |=> !out_err);
   a_r10_err_excludes_ok: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> !out_id_ok);

endmodule

bind intid_checker intid_checker_sva #(
   .CPU_ID_BITS (CPU_ID_BITS),
   .LPI_SUPPORT (LPI_SUPPORT),
   .EXT_IDS     (EXT_IDS)
) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .lpi_allowed   (lpi_allowed),
   .err_report_en (err_report_en),
   .out_valid     (out_valid),
   .out_kind      (out_kind),
   .out_id        (out_id),
   .out_id_ok     (out_id_ok),
   .out_err       (out_err),
   .width_q       (width_q)
);

// File: tb/intid_checker_test.sv
module intid_checker_test;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [2:0]  kind;
      logic [23:0] id;
      logic        ok;
      logic        err;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_width = 5'd24;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        lpi_allowed = 1'b1;
   logic        err_report_en = 1'b1;
   logic        out_valid;
   logic [2:0]  out_kind;
   logic [23:0] out_id;
   logic        out_id_ok;
   logic        out_err;

   int checks = 0;
   int errors = 0;
   int bench_w = 24;
   bit done = 1'b0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   intid_checker uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_width     (cfg_width),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .lpi_allowed   (lpi_allowed),
      .err_report_en (err_report_en),
      .out_valid     (out_valid),
      .out_kind      (out_kind),
      .out_id        (out_id),
      .out_id_ok     (out_id_ok),
      .out_err       (out_err)
   );

   function automatic exp_t model(input logic [63:0] d, input int w,
                                  input logic lpi, input logic en);
      exp_t e;
      logic [63:0] m;
      logic        up;
      int unsigned v;
      m  = d & ((64'd1 << w) - 64'd1);
      up = (d >> w) != 64'd0;
      v  = int'(m[31:0]);
      if (v < 16)                     e.kind = 3'd0;
      else if (v < 32)                e.kind = 3'd1;
      else if (v < 1020)              e.kind = 3'd2;
      else if (v < 1024)              e.kind = 3'd3;
      else if (v >= 1056 && v < 1120) e.kind = 3'd4;
      else if (v >= 4096 && v < 5120) e.kind = 3'd5;
      else if (v >= 8192)             e.kind = 3'd6;
      else                            e.kind = 3'd7;
      e.id  = m[23:0];
      e.err = en && (up || (e.kind == 3'd6 && !lpi));
      e.ok  = !up && !(e.kind == 3'd6 && !lpi) && e.kind != 3'd3 && e.kind != 3'd7;
      return e;
   endfunction

   task automatic check(input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [63:0] d, input logic lpi, input logic en,
                       input string tag);
      @(negedge clk);
      in_valid      = 1'b1;
      in_data       = d;
      lpi_allowed   = lpi;
      err_report_en = en;
      exp_q.push_back(model(d, bench_w, lpi, en));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic do_reset(input logic [4:0] req, input int expect_w);
      idle(3);
      rst_n     = 1'b0;
      cfg_width = req;
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      bench_w = expect_w;
      check("R11", "out_valid after reset", out_valid, 0);
      check("R11", "out_err after reset", out_err, 0);
      check("R11", "out_id_ok after reset", out_id_ok, 0);
      check("R11", "out_id after reset", out_id, 0);
   endtask

   // Monitor: compare results one step after each clock edge
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R1", "unexpected out_valid", 1, 0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "kind", out_kind, e.kind);
            check(t, "id", out_id, e.id);
            check(t, "ok", out_id_ok, e.ok);
            check(t, "err", out_err, e.err);
         end
      end else if (rst_n) begin
         if (out_err) check("R9", "err without valid", 1, 0);
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // Phase 1: width 24, stream of partition edges (R5, R7, R8, R10)
      do_reset(5'd24, 24);
      send(64'd0,     1, 1, "R5 sgi low");
      send(64'd15,    1, 1, "R5 sgi high");
      send(64'd16,    1, 1, "R5 ppi low");
      send(64'd31,    1, 1, "R10 ppi high");
      send(64'd32,    1, 1, "R5 spi low");
      send(64'd1019,  1, 1, "R10 spi high");
      send(64'd1020,  1, 1, "R7 special low");
      send(64'd1023,  1, 1, "R7 special high");
      send(64'd1024,  1, 1, "R8 hole1 low");
      send(64'd1055,  1, 1, "R8 hole1 high");
      send(64'd1056,  1, 1, "R5 eppi low");
      send(64'd1119,  1, 1, "R10 eppi high");
      send(64'd1120,  1, 1, "R8 hole2 low");
      send(64'd4095,  1, 1, "R8 hole2 high");
      send(64'd4096,  1, 1, "R5 espi low");
      send(64'd5119,  1, 1, "R10 espi high");
      send(64'd5120,  1, 1, "R8 hole3 low");
      send(64'd8191,  1, 1, "R8 hole3 high");
      send(64'd8192,  1, 1, "R10 lpi low");
      send(64'hFF_FFFF, 1, 1, "R10 lpi top");
      idle(2);
      // Upper bits, LPI permission, enable (R4, R6, R9, R1 gaps)
      send(64'h1_0000_0020, 1, 1, "R4 bit32");
      idle(1);
      send(64'h8000_0000_0000_0005, 1, 1, "R4 bit63");
      send(64'd8192,  0, 1, "R6 lpi blocked");
      send(64'd9000,  0, 0, "R9 lpi blocked no report");
      send(64'h1_0000_0020, 1, 0, "R9 upper no report");
      send(64'd40,    0, 1, "R6 spi with lpi off");
      idle(3);
      // Phase 2: oversized request clamps to 24 (R2, R3)
      do_reset(5'd30, 24);
      send(64'h100_0010, 1, 1, "R2 clamp hi bit24");
      send(64'h80_0000,  1, 1, "R3 bit23 kept");
      idle(3);
      // Phase 3: undersized request clamps to 14 (R2, R3, R4)
      do_reset(5'd3, 14);
      send(64'd8192,        1, 1, "R2 clamp lo bit13");
      send(64'd16389,       1, 1, "R4 bit14 masked");
      send(64'd12000,       0, 1, "R6 lpi narrow");
      idle(2);
      @(negedge clk);
      cfg_width = 5'd20;
      idle(2);
      send(64'd16389,       1, 1, "R2 cfg change ignored");
      send(64'h3_FFFF,      1, 1, "R3 mask to 14");
      idle(4);
      check("R1", "queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule